// File: doc/BRIEF.md
# Microcode Next-Address Dispatch Modifier

This block produces the bits that a microsequencer ORs onto the NEXT field of the following microinstruction when the current microinstruction asks for a dispatch. A dispatch can be on the macroinstruction held in the instruction register, on the value on the internal bus, or both. The result is a modifier word. The block registers it at the clock edge, so it applies to exactly one following microinstruction. It also returns to zero on its own unless it is produced again.

Four sources feed the modifier:
- a first-level merge of bus bits, taken when the instruction register is loaded;
- a 16-way instruction dispatch;
- an accumulator-source dispatch;
- a dispatch on the lowest bus bit.

The two instruction dispatches decode instruction fields through fixed priority tables, not through a flat opcode lookup. A load of the instruction register also sends a one-cycle pulse that clears the sequencer's skip flag.

Bit positions in the requirements are numbered with bit 0 as the most significant bit of a 16-bit word. So IR bit k is `ir_word[15-k]`, and a field IR[a-b] reads with IR[a] as its most significant bit.

Top module: `dmod_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mod_q` is 0 and `skip_clr` is 0.
- R2: When `ir_load` is 1, the next `mod_q` holds bus bit 0 at weight 8 and bus bits 5..7 (as a 3-bit number) at weights 4..1.
- R3: `skip_clr` is 1 in the cycle after a cycle with `ir_load` = 1, and 0 otherwise.
- R4: With `dsp_sel` = 1 (instruction dispatch) or 2 (accumulator-source dispatch) and IR[0] = 1, the contribution is 3 minus IR[8-9].
- R5: With `dsp_sel` = 1 and IR[0] = 0, the contribution follows this priority:
  - IR[1-2] = 0 gives IR[3-4];
  - IR[1-2] = 1 gives 4;
  - IR[1-2] = 2 gives 5.
  - Otherwise IR[4-7] is mapped: 0 gives 1, 1 gives 0, 6 gives 14, 14 gives 6, and any other value is passed through unchanged.
- R6: With `dsp_sel` = 2, IR[0] = 0 and IR[1-2] not equal to 3, the contribution is IR[5].
- R7: With `dsp_sel` = 2, IR[0] = 0 and IR[1-2] = 3, IR[3-7] is mapped:
  - 0 gives 2, 1 gives 5, 2 gives 3, 3 gives 6, 4 gives 7;
  - 9 gives 4, 10 gives 4, 14 gives 1, 31 gives 15;
  - any other value gives 14.
- R8: With `dsp_sel` = 3, the contribution is the least significant bus bit, at weight 1.
- R9: A contribution appears in `mod_q` exactly one cycle after the cycle that requested it. With `dsp_sel` = 0 and `ir_load` = 0, the next `mod_q` is 0.
- R10: When `ir_load` and a dispatch are requested in the same cycle, their contributions are combined by bitwise OR.
- R11: `upc_next` equals `next_fld` OR `mod_q` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_load | input | 1 | Strobe: the instruction register is loaded from the bus this cycle |
| dsp_sel | input | 2 | Dispatch request: 0 none, 1 instruction, 2 accumulator source, 3 bus odd |
| ir_word | input | 16 | Current instruction register contents |
| bus_word | input | 16 | Current bus value |
| next_fld | input | 10 | NEXT field of the executing microinstruction |
| mod_q | output | 10 | Registered modifier for the following microinstruction |
| skip_clr | output | 1 | One-cycle pulse that clears the skip flag |
| upc_next | output | 10 | Next microaddress, `next_fld` OR `mod_q` |

## Verification
A wrong table entry or field slice shows up on `mod_q` and `upc_next` exactly one clock after the requesting cycle. Because of that, the bench compares every cycle against an independent model and does not wait for an end-of-run check. A modifier that fails to clear shows as stale bits in the first idle cycle. A skip pulse that comes late or stays on shows on `skip_clr` in the cycle after the load. Every row of both tables is driven directly, and a long random run then mixes loads with dispatches.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

    localparam int WORD_W = 16;
    localparam int MOD_W  = 10;

    typedef enum logic [1:0] {
        DSP_NONE = 2'd0,
        DSP_OPC  = 2'd1,
        DSP_ACS  = 2'd2,
        DSP_ODD  = 2'd3
    } dsp_sel_e;

    typedef struct packed {
        logic [MOD_W-1:0] mod;
        logic             skip_clr;
    } dmod_state_t;

endpackage

// File: rtl/dmod_irmerge.sv
module dmod_irmerge #(
    parameter int WORD_W = 16,
    parameter int MOD_W  = 10
) (
    input  logic              en,
    input  logic [WORD_W-1:0] bus_w,
    output logic [MOD_W-1:0]  contrib
);
    // MSB-first bit k of the bus is bus_w[WORD_W-1-k]
    localparam int B0 = WORD_W - 1;
    localparam int B5 = WORD_W - 6;
    localparam int B7 = WORD_W - 8;

    always_comb begin
        contrib = '0;
        if (en) begin
            contrib[3]   = bus_w[B0];
            contrib[2:0] = bus_w[B5:B7];
        end
    end
endmodule

// File: rtl/dmod_opc.sv
module dmod_opc #(
    parameter int WORD_W = 16,
    parameter int MOD_W  = 10
) (
    input  logic              en,
    input  logic [WORD_W-1:0] ir_w,
    output logic [MOD_W-1:0]  contrib
);
    localparam int I0 = WORD_W - 1;

    logic [1:0] cls;
    logic [1:0] sh;
    logic [1:0] f34;
    logic [3:0] f47;
    logic [3:0] val;

    always_comb begin
        cls = ir_w[I0-1:I0-2];
        f34 = ir_w[I0-3:I0-4];
        f47 = ir_w[I0-4:I0-7];
        sh  = ir_w[I0-8:I0-9];
        if (ir_w[I0]) begin
            val = {2'b00, 2'd3 - sh};
        end else begin
            unique case (cls)
                2'd0: val = {2'b00, f34};
                2'd1: val = 4'd4;
                2'd2: val = 4'd5;
                default: begin
                    unique case (f47)
                        4'd0:    val = 4'd1;
                        4'd1:    val = 4'd0;
                        4'd6:    val = 4'd14;
                        4'd14:   val = 4'd6;
                        default: val = f47;
                    endcase
                end
            endcase
        end
        contrib = '0;
        if (en) contrib[3:0] = val;
    end
endmodule

// File: rtl/dmod_acs.sv
module dmod_acs #(
    parameter int WORD_W = 16,
    parameter int MOD_W  = 10
) (
    input  logic              en,
    input  logic [WORD_W-1:0] ir_w,
    output logic [MOD_W-1:0]  contrib
);
    localparam int I0 = WORD_W - 1;

    logic [1:0] cls;
    logic [1:0] sh;
    logic [4:0] f37;
    logic [3:0] val;

    always_comb begin
        cls = ir_w[I0-1:I0-2];
        f37 = ir_w[I0-3:I0-7];
        sh  = ir_w[I0-8:I0-9];
        if (ir_w[I0]) begin
            val = {2'b00, 2'd3 - sh};
        end else if (cls != 2'd3) begin
            val = {3'b000, ir_w[I0-5]};
        end else begin
            unique case (f37)
                5'd0:    val = 4'd2;
                5'd1:    val = 4'd5;
                5'd2:    val = 4'd3;
                5'd3:    val = 4'd6;
                5'd4:    val = 4'd7;
                5'd9:    val = 4'd4;
                5'd10:   val = 4'd4;
                5'd14:   val = 4'd1;
                5'd31:   val = 4'd15;
                default: val = 4'd14;
            endcase
        end
        contrib = '0;
        if (en) contrib[3:0] = val;
    end
endmodule

// File: rtl/dmod_top.sv
module dmod_top
    import dmod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_load,
    input  logic [1:0]        dsp_sel,
    input  logic [WORD_W-1:0] ir_word,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [MOD_W-1:0]  next_fld,
    output logic [MOD_W-1:0]  mod_q,
    output logic              skip_clr,
    output logic [MOD_W-1:0]  upc_next
);
    dsp_sel_e         sel;
    logic [MOD_W-1:0] c_ir;
    logic [MOD_W-1:0] c_opc;
    logic [MOD_W-1:0] c_acs;
    logic [MOD_W-1:0] c_odd;
    dmod_state_t      st_d;
    dmod_state_t      st_q;

    assign sel = dsp_sel_e'(dsp_sel);

    dmod_irmerge #(.WORD_W(WORD_W), .MOD_W(MOD_W)) u_irmerge (
        .en      (ir_load),
        .bus_w   (bus_word),
        .contrib (c_ir)
    );

    dmod_opc #(.WORD_W(WORD_W), .MOD_W(MOD_W)) u_opc (
        .en      (sel == DSP_OPC),
        .ir_w    (ir_word),
        .contrib (c_opc)
    );

    dmod_acs #(.WORD_W(WORD_W), .MOD_W(MOD_W)) u_acs (
        .en      (sel == DSP_ACS),
        .ir_w    (ir_word),
        .contrib (c_acs)
    );

    always_comb begin
        c_odd    = '0;
        c_odd[0] = (sel == DSP_ODD) & bus_word[0];
    end

    always_comb begin
        st_d          = '0;
        st_d.mod      = c_ir | c_opc | c_acs | c_odd;
        st_d.skip_clr = ir_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mod_q    = st_q.mod;
    assign skip_clr = st_q.skip_clr;
    assign upc_next = next_fld | st_q.mod;
endmodule

// File: rtl/dmod_chk.sv
module dmod_chk
    import dmod_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ir_load,
    input logic [1:0]        dsp_sel,
    input logic [WORD_W-1:0] ir_word,
    input logic [WORD_W-1:0] bus_word,
    input logic [MOD_W-1:0]  mod_q,
    input logic              skip_clr
);
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ir_load && dsp_sel == 2'd0) |=> (mod_q == '0)); // R9

    AST_SKIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> skip_clr); // R3

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> !skip_clr); // R3

    AST_LOAD_HIGH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_load && dsp_sel == 2'd0) |=> (mod_q[3] == $past(bus_word[WORD_W-1]))); // R2

    AST_ODD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_sel == 2'd3 && bus_word[0]) |=> mod_q[0]); // R8

    AST_SHIFT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ir_load && (dsp_sel == 2'd1 || dsp_sel == 2'd2) && ir_word[WORD_W-1])
        |=> (mod_q[3:0] == 4'd3 - {2'b00, $past(ir_word[WORD_W-9:WORD_W-10])})); // R4
endmodule

bind dmod_top dmod_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_load  (ir_load),
    .dsp_sel  (dsp_sel),
    .ir_word  (ir_word),
    .bus_word (bus_word),
    .mod_q    (mod_q),
    .skip_clr (skip_clr)
);

// File: tb/dmod_top_tb_top.sv
`timescale 1ns/1ps
module dmod_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_load = 1'b0;
    logic [1:0]  dsp_sel = 2'd0;
    logic [15:0] ir_word = '0;
    logic [15:0] bus_word = '0;
    logic [9:0]  next_fld = '0;
    logic [9:0]  mod_q;
    logic        skip_clr;
    logic [9:0]  upc_next;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dmod_top dut_i (
        .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .dsp_sel(dsp_sel),
        .ir_word(ir_word), .bus_word(bus_word), .next_fld(next_fld),
        .mod_q(mod_q), .skip_clr(skip_clr), .upc_next(upc_next)
    );

    // field of a word, MSB-first positions a..b inclusive
    function automatic int fld(input int w, input int a, input int b);
        return (w >> (15 - b)) & ((1 << (b - a + 1)) - 1);
    endfunction

    function automatic int ref_opc(input int ir);
        int k;
        if (fld(ir, 0, 0) == 1) return 3 - fld(ir, 8, 9);
        k = fld(ir, 1, 2);
        if (k == 0) return fld(ir, 3, 4);
        if (k == 1) return 4;
        if (k == 2) return 5;
        k = fld(ir, 4, 7);
        if (k == 0) return 1;
        if (k == 1) return 0;
        if (k == 6) return 14;
        if (k == 14) return 6;
        return k;
    endfunction

    function automatic int ref_acs(input int ir);
        int k;
        int tbl[32];
        if (fld(ir, 0, 0) == 1) return 3 - fld(ir, 8, 9);
        if (fld(ir, 1, 2) != 3) return fld(ir, 5, 5);
        foreach (tbl[i]) tbl[i] = 14;
        tbl[0] = 2; tbl[1] = 5; tbl[2] = 3; tbl[3] = 6; tbl[4] = 7;
        tbl[9] = 4; tbl[10] = 4; tbl[14] = 1; tbl[31] = 15;
        k = fld(ir, 3, 7);
        return tbl[k];
    endfunction

    function automatic int ref_mod(input bit ld, input int sel, input int ir, input int bus);
        int m = 0;
        if (ld) m = m | (fld(bus, 0, 0) * 8) | fld(bus, 5, 7);
        if (sel == 1) m = m | ref_opc(ir);
        if (sel == 2) m = m | ref_acs(ir);
        if (sel == 3) m = m | (bus & 1);
        return m;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Called just after a falling edge: drive, cross one rising edge, check at next falling edge
    task automatic step(input bit ld, input int sel, input int ir, input int bus, input string tag);
        int em;
        int nf;
        ir_load  = ld;
        dsp_sel  = sel[1:0];
        ir_word  = ir[15:0];
        bus_word = bus[15:0];
        em = ref_mod(ld, sel, ir, bus);
        @(posedge clk);
        @(negedge clk);
        nf = int'($urandom_range(0, 1023));
        next_fld = nf[9:0];
        #0.5;
        check(tag, "mod_q", int'(mod_q), em);
        check("R3", "skip_clr", int'(skip_clr), int'(ld));
        check("R11", "upc_next", int'(upc_next), nf | em);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "mod_q in reset", int'(mod_q), 0);
        check("R1", "skip_clr in reset", int'(skip_clr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "mod_q after reset", int'(mod_q), 0);
        check("R1", "skip_clr after reset", int'(skip_clr), 0);

        // R2 / R3: IR-load merge
        step(1, 0, 0, 16'h8000, "R2");
        step(1, 0, 0, 16'h0700, "R2");
        step(1, 0, 0, 16'h78FF, "R2");
        step(1, 0, 0, 16'h8500, "R2");
        step(0, 0, 0, 16'hFFFF, "R9");

        // R4: shift-field case for both dispatches
        for (int s = 0; s < 4; s++) begin
            step(0, 1, 16'h8000 | (s << 6), 0, "R4");
            step(0, 2, 16'hF000 | (s << 6), 0, "R4");
        end

        // R5: instruction dispatch classes
        for (int j = 0; j < 4; j++) step(0, 1, j << 11, 0, "R5");
        step(0, 1, 16'h2000, 0, "R5");
        step(0, 1, 16'h4000, 0, "R5");
        for (int f = 0; f < 16; f++) step(0, 1, 16'h6000 | (f << 8), 0, "R5");
        step(0, 1, 16'h7E00 | 16'h00FF, 0, "R5");

        // R6: indirect bit for non-class-3
        for (int c = 0; c < 3; c++) begin
            step(0, 2, (c << 13), 0, "R6");
            step(0, 2, (c << 13) | 16'h0400, 0, "R6");
        end

        // R7: class-3 accumulator-source table, every code
        for (int f = 0; f < 32; f++) step(0, 2, 16'h6000 | (f << 8), 0, "R7");

        // R8: bus-odd
        step(0, 3, 0, 16'hFFFE, "R8");
        step(0, 3, 0, 16'h0001, "R8");

        // R9: idle clears
        step(0, 0, 16'h8000, 16'hFFFF, "R9");

        // R10: combined sources
        step(1, 1, 16'h6600, 16'h0100, "R10");
        step(1, 2, 16'h7F00, 16'h8000, "R10");
        step(1, 3, 0, 16'h0201, "R10");

        // random mix
        for (int i = 0; i < 400; i++)
            step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule